// File: doc/BRIEF.md
# Stack CPU Opcode Decoder

This block sits at the front of a zero-operand stack processor. It accepts one 8-bit opcode per clock, together with a valid strobe and the current top-of-stack word. Each cycle it reports a micro-operation class, a byte offset relative to the stack pointer, an immediate word and, for opcodes that the active instruction set does not run in hardware, the address of the software handler. Two flags mark a breakpoint opcode and an undefined opcode. Executing the operation, the stack memory and the program counter belong to the surrounding pipeline.

The decoder holds only two bits of state. The first, the chaining flag, records whether the last accepted opcode was an immediate. A run of immediate opcodes can then build a wide constant seven bits at a time. The second, the set selector, chooses between the full instruction set and a reduced set. A configuration opcode changes the selector at run time. In the reduced set, the opcodes it does not run natively are routed to per-opcode vectors.

Top module: `stk_op_decode`

## Requirements
- R1: After reset the full set is selected (`fullSel`=1) and the chaining flag is clear. While `opValid` is low, `opClass` is 0 (idle), both flags are 0, and `slotOffset`, `immValue` and `trapAddr` are 0.
- R2: An opcode with bit 7 set that does not follow an accepted immediate gives class 1. `immValue` is its low 7 bits sign-extended to 32 bits.
- R3: An opcode with bit 7 set that directly follows an accepted immediate gives class 2. `immValue` is (`tosIn` << 7) | low 7 bits.
- R4: An accepted opcode with bit 7 clear clears the chaining flag. A cycle with `opValid` low leaves the flag unchanged.
- R5: Opcodes 16..31 give class 3 with `slotOffset` = 4*(opcode-16).
- R6: Opcodes 96..127 give class 4 (stack load) and opcodes 64..95 give class 5 (stack store). In both cases `slotOffset` = 4*((opcode-base) XOR 16).
- R7: Opcode 0 gives class 9 with `isBreak`=1 and `isIllegal`=0.
- R8: Opcodes 1, 3, 14, 15, 32 and 33 give class 10 with `isIllegal`=1. Opcode 60 is illegal in the same way while the reduced set is selected.
- R9: With the full set selected, opcodes 2, 4..13 and 34..63 except 58 give class 6 (native) with `trapAddr`=0.
- R10: With the reduced set selected, opcodes 34, 35, 37, 39, 42, 43, 44, 47, 48, 50, 53, 54, 55 and 57 give class 7 (trap) with `trapAddr` = (opcode-32)*32. Opcodes 36, 38, 41, 45, 46, 49, 51, 52, 56, 61 and 63, and also 40, 59 and 62, stay class 6.
- R11: Opcode 58 gives class 8. At the next edge a `tosIn` of 1 selects the full set and a `tosIn` of 0 selects the reduced set. Any other value leaves `fullSel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Opcode strobe; state updates only while high |
| opcode | input | 8 | Opcode byte |
| tosIn | input | 32 | Current top-of-stack word (chaining base, config operand) |
| opClass | output | 4 | Micro-operation class code |
| slotOffset | output | 7 | Byte offset from the stack pointer |
| immValue | output | 32 | Immediate word to push or to replace the top |
| trapAddr | output | 16 | Handler address for a trapped opcode |
| isBreak | output | 1 | Breakpoint opcode seen |
| isIllegal | output | 1 | Undefined opcode seen |
| fullSel | output | 1 | 1 = full instruction set selected |

## Verification
The bench targets chaining across an idle gap: a decoder that cleared the flag on invalid cycles would restart a constant instead of extending it. It checks sign extension of the 7-bit field with bit 6 set, and a wrong extension shows up as a positive value. It checks slot offsets at both ends and at the XOR wrap point of each range, where a missing XOR swaps the upper and lower halves. It also steps through config operands 0, 1 and an out-of-range value. Here a decoder that treated any nonzero operand as "full", or that trapped the wrong members of the reduced set, would give the wrong class or handler address.

// File: rtl/stk_dec_pkg.sv
package stk_dec_pkg;

  localparam int CLASS_W   = 4;
  localparam int SLOT_OFS_W = 7;

  typedef enum logic [CLASS_W-1:0] {
    OP_IDLE      = 4'd0,
    OP_IMM_NEW   = 4'd1,
    OP_IMM_CHAIN = 4'd2,
    OP_ADD_SP    = 4'd3,
    OP_LOAD_SP   = 4'd4,
    OP_STORE_SP  = 4'd5,
    OP_NATIVE    = 4'd6,
    OP_TRAP      = 4'd7,
    OP_CONFIG    = 4'd8,
    OP_BREAK     = 4'd9,
    OP_ILLEGAL   = 4'd10
  } opClassE;

  // strobes from control to datapath
  typedef struct packed {
    logic immNew;
    logic immChain;
    logic addSp;
    logic loadSp;
    logic storeSp;
    logic trap;
  } decStrobeS;

endpackage

// File: rtl/stk_dec_ctrl.sv
module stk_dec_ctrl
  import stk_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] tosIn,
  output opClassE           opClass,
  output decStrobeS         strobe,
  output logic              isBreak,
  output logic              isIllegal,
  output logic              fullSel
);

  localparam logic [7:0] ADD_BASE   = 8'd16;
  localparam logic [7:0] STORE_BASE = 8'd64;
  localparam logic [7:0] LOAD_BASE  = 8'd96;
  localparam logic [7:0] EXT_BASE   = 8'd32;
  localparam logic [7:0] OPC_CFG    = 8'd58;
  localparam logic [7:0] OPC_SYS    = 8'd60;
  // bit (op-32) set: trapped while the reduced set is selected
  localparam logic [31:0] TRAP_MASK =
      (32'd1 << 2)  | (32'd1 << 3)  | (32'd1 << 5)  | (32'd1 << 7)  |
      (32'd1 << 10) | (32'd1 << 11) | (32'd1 << 12) | (32'd1 << 15) |
      (32'd1 << 16) | (32'd1 << 18) | (32'd1 << 21) | (32'd1 << 22) |
      (32'd1 << 23) | (32'd1 << 25);

  logic chainQ;
  logic fullQ;
  logic [4:0] extIdx;

  assign extIdx = opcode[4:0];

  always_comb begin
    opClass = OP_IDLE;
    if (opValid) begin
      if (opcode[7]) begin
        opClass = chainQ ? OP_IMM_CHAIN : OP_IMM_NEW;
      end else if (opcode >= LOAD_BASE) begin
        opClass = OP_LOAD_SP;
      end else if (opcode >= STORE_BASE) begin
        opClass = OP_STORE_SP;
      end else if (opcode >= EXT_BASE) begin
        if (opcode == OPC_CFG) begin
          opClass = OP_CONFIG;
        end else if (opcode == OPC_SYS) begin
          opClass = fullQ ? OP_NATIVE : OP_ILLEGAL;
        end else if (opcode < EXT_BASE + 8'd2) begin
          opClass = OP_ILLEGAL;
        end else if (!fullQ && TRAP_MASK[extIdx]) begin
          opClass = OP_TRAP;
        end else begin
          opClass = OP_NATIVE;
        end
      end else if (opcode >= ADD_BASE) begin
        opClass = OP_ADD_SP;
      end else if (opcode == 8'd0) begin
        opClass = OP_BREAK;
      end else if (opcode == 8'd2 || (opcode >= 8'd4 && opcode <= 8'd13)) begin
        opClass = OP_NATIVE;
      end else begin
        opClass = OP_ILLEGAL;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.immNew   = (opClass == OP_IMM_NEW);
    strobe.immChain = (opClass == OP_IMM_CHAIN);
    strobe.addSp    = (opClass == OP_ADD_SP);
    strobe.loadSp   = (opClass == OP_LOAD_SP);
    strobe.storeSp  = (opClass == OP_STORE_SP);
    strobe.trap     = (opClass == OP_TRAP);
  end

  assign isBreak   = (opClass == OP_BREAK);
  assign isIllegal = (opClass == OP_ILLEGAL);
  assign fullSel   = fullQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= 1'b0;
      fullQ  <= 1'b1;
    end else if (opValid) begin
      chainQ <= opcode[7];
      if (opClass == OP_CONFIG) begin
        if (tosIn == DATA_W'(1))      fullQ <= 1'b1;
        else if (tosIn == '0)         fullQ <= 1'b0;
      end
    end
  end

  a_r4_chain_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(chainQ));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (opClass == OP_IDLE && !isBreak && !isIllegal));
  a_r11_cfg_keep: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode == OPC_CFG && tosIn > DATA_W'(1)) |=> $stable(fullSel));
  a_r7_break_only: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode == 8'd0) |-> (isBreak && !isIllegal));
  a_r3_chain_after_imm: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode[7]) ##1 (opValid && opcode[7]) |-> opClass == OP_IMM_CHAIN);

endmodule

// File: rtl/stk_dec_dp.sv
module stk_dec_dp
  import stk_dec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int IMM_BITS = 7,
  parameter int VEC_SIZE = 32,
  parameter int VEC_BASE = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            opcode,
  input  logic [DATA_W-1:0]     tosIn,
  input  decStrobeS             strobe,
  output logic [SLOT_OFS_W-1:0] slotOffset,
  output logic [DATA_W-1:0]     immValue,
  output logic [ADDR_W-1:0]     trapAddr
);

  localparam int SLOT_W = SLOT_OFS_W - 2;
  localparam logic [SLOT_W-1:0] SLOT_FLIP = SLOT_W'(16);
  localparam logic [7:0] ADD_BASE   = 8'd16;
  localparam logic [7:0] STORE_BASE = 8'd64;
  localparam logic [7:0] LOAD_BASE  = 8'd96;
  localparam int VEC_SHIFT = $clog2(VEC_SIZE);

  logic [SLOT_W-1:0] slotIdx;
  logic [ADDR_W-1:0] vecIdx;
  logic [DATA_W-1:0] immLow;

  always_comb begin
    slotIdx = '0;
    if (strobe.addSp)        slotIdx = SLOT_W'(opcode - ADD_BASE);
    else if (strobe.loadSp)  slotIdx = SLOT_W'(opcode - LOAD_BASE) ^ SLOT_FLIP;
    else if (strobe.storeSp) slotIdx = SLOT_W'(opcode - STORE_BASE) ^ SLOT_FLIP;
  end

  assign slotOffset = {slotIdx, 2'b00};

  assign immLow = DATA_W'(opcode[IMM_BITS-1:0]);

  always_comb begin
    immValue = '0;
    if (strobe.immNew)
      immValue = {{(DATA_W-IMM_BITS){opcode[IMM_BITS-1]}}, opcode[IMM_BITS-1:0]};
    else if (strobe.immChain)
      immValue = (tosIn << IMM_BITS) | immLow;
  end

  assign vecIdx   = ADDR_W'(opcode) - ADDR_W'(32);
  assign trapAddr = strobe.trap ? (ADDR_W'(VEC_BASE) + (vecIdx * ADDR_W'(VEC_SIZE))) : '0;

  a_r10_trap_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trap |-> trapAddr[VEC_SHIFT-1:0] == '0);
  a_r2_sign_fill: assert property (@(posedge clk) disable iff (!rstN)
    strobe.immNew |-> (immValue[DATA_W-1:IMM_BITS-1] == '0 ||
                       immValue[DATA_W-1:IMM_BITS-1] == '1));
  a_r12_fields_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |-> (slotOffset == '0 && immValue == '0 && trapAddr == '0));

endmodule

// File: rtl/stk_op_decode.sv
module stk_op_decode
  import stk_dec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int IMM_BITS = 7,
  parameter int VEC_SIZE = 32,
  parameter int VEC_BASE = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [7:0]            opcode,
  input  logic [DATA_W-1:0]     tosIn,
  output logic [CLASS_W-1:0]    opClass,
  output logic [SLOT_OFS_W-1:0] slotOffset,
  output logic [DATA_W-1:0]     immValue,
  output logic [ADDR_W-1:0]     trapAddr,
  output logic                  isBreak,
  output logic                  isIllegal,
  output logic                  fullSel
);

  opClassE   classE;
  decStrobeS strobe;

  stk_dec_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode), .tosIn(tosIn),
    .opClass(classE), .strobe(strobe), .isBreak(isBreak), .isIllegal(isIllegal),
    .fullSel(fullSel)
  );

  stk_dec_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_BITS(IMM_BITS),
    .VEC_SIZE(VEC_SIZE), .VEC_BASE(VEC_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .opcode(opcode), .tosIn(tosIn), .strobe(strobe),
    .slotOffset(slotOffset), .immValue(immValue), .trapAddr(trapAddr)
  );

  assign opClass = classE;

endmodule

// File: tb/stk_op_decode_test.sv
module stk_op_decode_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opcode = 8'd0;
  logic [31:0] tosIn = 32'd0;
  logic [3:0]  opClass;
  logic [6:0]  slotOffset;
  logic [31:0] immValue;
  logic [15:0] trapAddr;
  logic        isBreak, isIllegal, fullSel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stk_op_decode uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode), .tosIn(tosIn),
    .opClass(opClass), .slotOffset(slotOffset), .immValue(immValue),
    .trapAddr(trapAddr), .isBreak(isBreak), .isIllegal(isIllegal), .fullSel(fullSel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one opcode away from the edge; outputs settle before the next edge
  task automatic drive(input logic v, input logic [7:0] op, input logic [31:0] tos);
    @(negedge clk);
    opValid = v; opcode = op; tosIn = tos;
    #1;
  endtask

  task automatic t_reset;
    drive(1'b0, 8'h85, 32'hFFFF_FFFF);
    chk("R1 class", opClass, 0);
    chk("R1 fullSel", fullSel, 1);
    chk("R1 flags", {isBreak, isIllegal}, 0);
    chk("R1 fields", slotOffset | immValue | trapAddr, 0);
    drive(1'b1, 8'h85, 32'h0);
    chk("R2 first imm after reset class", opClass, 1);
    chk("R2 imm value", immValue, 32'd5);
  endtask

  task automatic t_imm;
    drive(1'b1, 8'hFF, 32'd5);
    chk("R3 chain class", opClass, 2);
    chk("R3 chain value", immValue, (32'd5 << 7) | 32'h7F);
    drive(1'b1, 8'd11, 32'd0);
    chk("R9 nop native", opClass, 6);
    drive(1'b1, 8'hC0, 32'd0);
    chk("R4 cleared -> new imm class", opClass, 1);
    chk("R2 sign-extended", immValue, 32'hFFFF_FFC0);
    drive(1'b0, 8'd0, 32'd0);
    drive(1'b0, 8'd5, 32'd0);
    drive(1'b1, 8'h81, 32'h1234_5678);
    chk("R4 gap keeps chain class", opClass, 2);
    chk("R3 chain value wide", immValue, (32'h1234_5678 << 7) | 32'd1);
  endtask

  task automatic t_addsp;
    drive(1'b1, 8'd16, 32'd0);
    chk("R5 class", opClass, 3);
    chk("R5 offset op16", slotOffset, 0);
    drive(1'b1, 8'd31, 32'd0);
    chk("R5 offset op31", slotOffset, 60);
    chk("R5 imm zero", immValue, 0);
  endtask

  task automatic t_slots;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] op, base;
      op = (k == 0) ? 8'd96 : (k == 1) ? 8'd111 : (k == 2) ? 8'd112 :
           (k == 3) ? 8'd64 : (k == 4) ? 8'd95 : 8'd80;
      base = (k < 3) ? 8'd96 : 8'd64;
      drive(1'b1, op, 32'd0);
      chk("R6 class", opClass, (k < 3) ? 4 : 5);
      chk("R6 offset", slotOffset, 4 * (32'(op - base) ^ 32'd16));
    end
  endtask

  task automatic t_break_illegal;
    drive(1'b1, 8'd0, 32'd0);
    chk("R7 class", opClass, 9);
    chk("R7 flags", {isBreak, isIllegal}, 2'b10);
    foreach (ILL[i]) begin
      drive(1'b1, ILL[i], 32'd0);
      chk("R8 class", opClass, 10);
      chk("R8 flags", {isBreak, isIllegal}, 2'b01);
    end
  endtask

  logic [7:0] ILL [6] = '{8'd1, 8'd3, 8'd14, 8'd15, 8'd32, 8'd33};
  logic [7:0] TRP [14] = '{8'd34, 8'd35, 8'd37, 8'd39, 8'd42, 8'd43, 8'd44,
                           8'd47, 8'd48, 8'd50, 8'd53, 8'd54, 8'd55, 8'd57};
  logic [7:0] NAT [14] = '{8'd36, 8'd38, 8'd41, 8'd45, 8'd46, 8'd49, 8'd51,
                           8'd52, 8'd56, 8'd61, 8'd63, 8'd40, 8'd59, 8'd62};

  task automatic t_full;
    foreach (TRP[i]) begin
      drive(1'b1, TRP[i], 32'd0);
      chk("R9 full set native", opClass, 6);
      chk("R9 no trap addr", trapAddr, 0);
    end
    drive(1'b1, 8'd60, 32'd0);
    chk("R9 op60 native in full set", opClass, 6);
    drive(1'b1, 8'd2, 32'd0);
    chk("R9 op2 native", opClass, 6);
  endtask

  task automatic t_config;
    drive(1'b1, 8'd58, 32'd7);
    chk("R11 config class", opClass, 8);
    drive(1'b1, 8'd58, 32'd0);
    chk("R11 operand 7 keeps full", fullSel, 1);
    drive(1'b0, 8'd0, 32'd0);
    chk("R11 operand 0 selects reduced", fullSel, 0);
    foreach (TRP[i]) begin
      drive(1'b1, TRP[i], 32'd0);
      chk("R10 trap class", opClass, 7);
      chk("R10 trap addr", trapAddr, 32'(TRP[i] - 8'd32) * 32);
    end
    foreach (NAT[i]) begin
      drive(1'b1, NAT[i], 32'd0);
      chk("R10 reduced native", opClass, 6);
    end
    drive(1'b1, 8'd60, 32'd0);
    chk("R8 op60 illegal in reduced set", opClass, 10);
    drive(1'b1, 8'd58, 32'd2);
    drive(1'b1, 8'd58, 32'd1);
    chk("R11 operand 2 keeps reduced", fullSel, 0);
    drive(1'b1, 8'd37, 32'd0);
    chk("R11 operand 1 selects full", fullSel, 1);
    chk("R11 op37 native again", opClass, 6);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_imm();
    t_addsp();
    t_slots();
    t_break_illegal();
    t_full();
    t_config();
    drive(1'b0, 8'd0, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule